// File: doc/BRIEF.md
# Strap-Latching Host Configuration Register File

This block sits behind the host register bus of a display controller. When the active-low reset is released it freezes the sixteen configuration strap pins, and the host can then read them back as two read-only bytes. It also holds one control register with three bits. The first is a host lockout bit that is set by reset. The second is a software suspend enable. The third is a half-frame-buffer disable. Decoded outputs carry these settings to the rest of the chip.

The lockout bit starts at 1, and while it is set the host can reach only two addresses: the status byte at 0x1A and the control register at 0x1B. Every other register access is refused, and the memory-access permission output stays low. Software clears the lockout by writing 0 to bit 7 of 0x1B, and it can set the bit again later. A blocked access, whether a read or a write, causes a one-cycle reject pulse. A blocked read returns 0x00.

A small state machine with the states LK_LOCKED and LK_OPEN holds the lockout. The transition UNLOCK (a write to 0x1B with bit 7 clear) takes LK_LOCKED to LK_OPEN, and the transition RELOCK (a write to 0x1B with bit 7 set) takes LK_OPEN back to LK_LOCKED. A second state machine records the outcome of each bus cycle, which is RD_IDLE, RD_GRANT or RD_REJECT. Its transitions are NO_ACCESS, ALLOWED and BLOCKED, and the reject output is decoded from this state.

Top module: `hostcfg_regs`

## Requirements
- R1: The strap value present at the last clock edge while rst_n is low is captured, and it stays unchanged until the next reset, whatever the strap pins do afterwards.
- R2: Address 0x1C reads strap bits 7..0 and address 0x1D reads strap bits 15..8. Writes to these two addresses change nothing.
- R3: After reset, 0x1B reads 0x80, host_locked is 1, mem_access_ok is 0 and suspend_en is 0.
- R4: A write to 0x1B with bit 7 = 0 clears the lockout from the next cycle. A write with bit 7 = 1 sets it again.
- R5: While locked, a read of any address other than 0x1A or 0x1B returns 0x00 and is rejected. A write to such an address is ignored and rejected.
- R6: mem_access_ok is 1 exactly when the lockout is clear.
- R7: In register 0x1B, bit 7 is the lockout, bit 6 is the suspend enable and bit 0 is the half-frame-buffer disable. Bits 5..1 always read 0, whatever value is written to them.
- R8: suspend_en follows bit 6 of 0x1B.
- R9: hfb_en is 0 whenever single_panel is 1 or bit 0 of 0x1B is 1, and it is 1 otherwise.
- R10: 0x1A returns status_in at any time, even while locked, and a write to 0x1A has no effect.
- R11: Read data appears in the cycle after the read strobe. In every cycle that does not follow a read, reg_rdata is 0x00. An unmapped address reads 0x00 without a reject when the lockout is clear.
- R12: reg_rej is 1 for one cycle after a blocked access, and it is 0 after every allowed access and after every idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release freezes the straps |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| reg_rej | output | 1 | Previous access was blocked |
| strap_in | input | 16 | Configuration strap pins |
| status_in | input | 8 | Byte returned at 0x1A |
| single_panel | input | 1 | Single-panel mode select |
| host_locked | output | 1 | Lockout bit is set |
| mem_access_ok | output | 1 | Memory access permitted |
| suspend_en | output | 1 | Software suspend enable |
| hfb_en | output | 1 | Effective half-frame-buffer enable |

## Verification
The bench changes the strap pins straight after reset is released and again in the middle of the run. A design that samples the pins too late, or that keeps tracking them, would then read back the new values instead of the frozen ones. While the lockout is set it reads and writes the strap bytes and unmapped addresses, and it writes a strap byte after unlocking and then reads it back. A leaky gate would show through as a non-zero read, a missing reject pulse or a changed strap byte. It writes all ones to 0x1B, unlocks the block and locks it again, and drives single_panel against the disable bit. A design with a wrong bit mask, a one-way lockout or an OR'd enable would read back stray bits, stay unlocked or raise hfb_en. A second reset checks that the straps are captured again and that the lockout returns.

// File: rtl/hostcfg_pkg.sv
package hostcfg_pkg;

    localparam int unsigned REG_W = 8;

    // Register map (addresses are fixed by the host software interface)
    localparam int unsigned ADR_STATUS   = 'h1A;
    localparam int unsigned ADR_MISC     = 'h1B;
    localparam int unsigned ADR_STRAP0   = 'h1C;

    // Control register bit positions
    localparam int unsigned BIT_LOCK     = 7;
    localparam int unsigned BIT_SUSPEND  = 6;
    localparam int unsigned BIT_HFB_OFF  = 0;

    localparam logic [REG_W-1:0] MISC_RESET = 8'h80;

    typedef enum logic {
        LK_LOCKED,
        LK_OPEN
    } lock_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_GRANT,
        RD_REJECT
    } acc_state_e;

endpackage

// File: rtl/hostcfg_strap_latch.sv
module hostcfg_strap_latch #(
    parameter int unsigned STRAP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q
);

    // Track the pins while reset is held; the last sample before release stays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_in;
        end
    end

endmodule

// File: rtl/hostcfg_misc_ctrl.sv
module hostcfg_misc_ctrl
    import hostcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             misc_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             single_panel,
    output logic [REG_W-1:0] misc_byte,
    output logic             locked,
    output logic             mem_ok,
    output logic             suspend_en,
    output logic             hfb_en
);

    lock_state_e state_q, state_d;
    logic        susp_q;
    logic        hfb_off_q;

    // Lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: UNLOCK and RELOCK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (misc_we && !wdata[BIT_LOCK]) state_d = LK_OPEN;
            LK_OPEN:   if (misc_we &&  wdata[BIT_LOCK]) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // Plain control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            susp_q    <= MISC_RESET[BIT_SUSPEND];
            hfb_off_q <= MISC_RESET[BIT_HFB_OFF];
        end else if (misc_we) begin
            susp_q    <= wdata[BIT_SUSPEND];
            hfb_off_q <= wdata[BIT_HFB_OFF];
        end
    end

    // Outputs
    always_comb begin
        locked     = 1'b0;
        mem_ok     = 1'b0;
        unique case (state_q)
            LK_LOCKED: begin
                locked = 1'b1;
                mem_ok = 1'b0;
            end
            LK_OPEN: begin
                locked = 1'b0;
                mem_ok = 1'b1;
            end
            default: begin
                locked = 1'b1;
                mem_ok = 1'b0;
            end
        endcase
        suspend_en             = susp_q;
        hfb_en                 = !(single_panel || hfb_off_q);
        misc_byte              = '0;
        misc_byte[BIT_LOCK]    = locked;
        misc_byte[BIT_SUSPEND] = susp_q;
        misc_byte[BIT_HFB_OFF] = hfb_off_q;
    end

endmodule

// File: rtl/hostcfg_access_port.sv
module hostcfg_access_port
    import hostcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned STRAP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic               locked,
    input  logic [REG_W-1:0]   status_byte,
    input  logic [REG_W-1:0]   misc_byte,
    input  logic [STRAP_W-1:0] strap_q,
    output logic               misc_we,
    output logic [REG_W-1:0]   rdata,
    output logic               rej
);

    localparam int unsigned NBYTES = STRAP_W / REG_W;

    acc_state_e       state_q, state_d;
    logic [REG_W-1:0] rdata_q, rdata_d;
    logic             hit_status, hit_misc, always_open, allowed, access;
    logic [NBYTES-1:0] hit_strap;
    logic [REG_W-1:0]  strap_bytes [NBYTES];
    logic [REG_W-1:0]  strap_sel;

    assign hit_status  = (addr == ADDR_W'(ADR_STATUS));
    assign hit_misc    = (addr == ADDR_W'(ADR_MISC));
    assign always_open = hit_status || hit_misc;
    assign allowed     = always_open || !locked;
    assign access      = rd || wr;
    assign misc_we     = wr && hit_misc;

    // One decode and one byte lane per strap byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_strap
        assign hit_strap[b]   = (addr == ADDR_W'(ADR_STRAP0 + b));
        assign strap_bytes[b] = hit_strap[b] ? strap_q[b*REG_W +: REG_W] : '0;
    end

    always_comb begin
        strap_sel = '0;
        for (int b = 0; b < NBYTES; b++) begin
            strap_sel = strap_sel | strap_bytes[b];
        end
    end

    // Transitions: NO_ACCESS, ALLOWED, BLOCKED
    always_comb begin
        state_d = RD_IDLE;
        unique case (state_q)
            RD_IDLE, RD_GRANT, RD_REJECT: begin
                if (!access)      state_d = RD_IDLE;
                else if (allowed) state_d = RD_GRANT;
                else              state_d = RD_REJECT;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        rdata_d = '0;
        if (rd && allowed) begin
            if (hit_status)    rdata_d = status_byte;
            else if (hit_misc) rdata_d = misc_byte;
            else               rdata_d = strap_sel;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs
    always_comb begin
        rej   = 1'b0;
        rdata = rdata_q;
        unique case (state_q)
            RD_IDLE:   rej = 1'b0;
            RD_GRANT:  rej = 1'b0;
            RD_REJECT: rej = 1'b1;
            default:   rej = 1'b0;
        endcase
    end

endmodule

// File: rtl/hostcfg_regs.sv
module hostcfg_regs
    import hostcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned STRAP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               reg_rej,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic [REG_W-1:0]   status_in,
    input  logic               single_panel,
    output logic               host_locked,
    output logic               mem_access_ok,
    output logic               suspend_en,
    output logic               hfb_en
);

    logic [STRAP_W-1:0] strap_q;
    logic [REG_W-1:0]   misc_byte;
    logic               misc_we;

    hostcfg_strap_latch #(.STRAP_W(STRAP_W)) strap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .strap_q  (strap_q)
    );

    hostcfg_misc_ctrl misc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .misc_we      (misc_we),
        .wdata        (reg_wdata),
        .single_panel (single_panel),
        .misc_byte    (misc_byte),
        .locked       (host_locked),
        .mem_ok       (mem_access_ok),
        .suspend_en   (suspend_en),
        .hfb_en       (hfb_en)
    );

    hostcfg_access_port #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .rd          (reg_rd),
        .wr          (reg_wr),
        .locked      (host_locked),
        .status_byte (status_in),
        .misc_byte   (misc_byte),
        .strap_q     (strap_q),
        .misc_we     (misc_we),
        .rdata       (reg_rdata),
        .rej         (reg_rej)
    );

endmodule

// File: rtl/hostcfg_regs_chk.sv
module hostcfg_regs_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned STRAP_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic               reg_rej,
    input logic               single_panel,
    input logic               host_locked,
    input logic               hfb_en,
    input logic [STRAP_W-1:0] strap_q
);

    // R1: frozen strap value never moves while out of reset
    a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

    // R4: clearing the lock bit opens access on the next cycle
    a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h1B) && !reg_wdata[7]) |=> !host_locked);

    // R5: locked read of a strap byte returns zero and is rejected
    a_r5_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_locked && reg_rd && reg_addr == ADDR_W'('h1C)) |=> (reg_rdata == 8'h00 && reg_rej));

    // R9: single panel forces the half frame buffer off
    a_r9_single_panel: assert property (@(posedge clk) disable iff (!rst_n)
        single_panel |-> !hfb_en);

    // R11: no read strobe, no read data
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == 8'h00));

    // R12: a reject only follows an access made while locked
    a_r12_rej_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rej |-> ($past(host_locked) && ($past(reg_rd) || $past(reg_wr))));

endmodule

bind hostcfg_regs hostcfg_regs_chk #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .reg_rej      (reg_rej),
    .single_panel (single_panel),
    .host_locked  (host_locked),
    .hfb_en       (hfb_en),
    .strap_q      (strap_q)
);

// File: tb/hostcfg_regs_tb_top.sv
module hostcfg_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_rej;
    logic [15:0] strap_in = '0;
    logic [7:0]  status_in = 8'h3C;
    logic        single_panel = 1'b0;
    logic        host_locked, mem_access_ok, suspend_en, hfb_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       rej;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    hostcfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rej(reg_rej), .strap_in(strap_in), .status_in(status_in),
        .single_panel(single_panel), .host_locked(host_locked),
        .mem_access_ok(mem_access_ok), .suspend_en(suspend_en), .hfb_en(hfb_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one access per two cycles, expected outcome pushed to the scoreboard
    task automatic access(input bit is_wr, input logic [7:0] a, input logic [7:0] wd,
                          input logic [7:0] exp_d, input logic exp_r, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = wd;
        reg_wr    = is_wr;
        reg_rd    = !is_wr;
        e.data = exp_d; e.rej = exp_r; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    // Monitor: compare each result one clock after its strobe
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " rdata"}, reg_rdata, e.data);
                check({e.tag, " rej"}, {7'b0, reg_rej}, {7'b0, e.rej});
            end
        end
    end

    task automatic do_reset(input logic [15:0] s);
        @(negedge clk);
        rst_n    = 1'b0;
        strap_in = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_in = ~s;  // pins move after release
    endtask

    initial begin
        do_reset(16'hA55A);
        @(negedge clk);
        // R3: reset state
        check("R3 host_locked", {7'b0, host_locked}, 8'h01);
        check("R6 mem_access_ok locked", {7'b0, mem_access_ok}, 8'h00);
        check("R3 suspend_en", {7'b0, suspend_en}, 8'h00);
        check("R9 hfb_en reset", {7'b0, hfb_en}, 8'h01);
        access(0, 8'h1B, 8'h00, 8'h80, 1'b0, "R3 misc reset");
        // R5: locked gate
        access(0, 8'h1C, 8'h00, 8'h00, 1'b1, "R5 locked read strap");
        access(0, 8'h40, 8'h00, 8'h00, 1'b1, "R5 locked read unmapped");
        access(1, 8'h1D, 8'hFF, 8'h00, 1'b1, "R5 locked write strap");
        // R10: status always open, write ignored
        access(0, 8'h1A, 8'h00, 8'h3C, 1'b0, "R10 status locked");
        access(1, 8'h1A, 8'h99, 8'h00, 1'b0, "R10 status write");
        access(0, 8'h1A, 8'h00, 8'h3C, 1'b0, "R10 status after write");
        // R4/R7: unlock with all other bits set
        access(1, 8'h1B, 8'h7F, 8'h00, 1'b0, "R4 unlock write");
        check("R4 unlocked", {7'b0, host_locked}, 8'h00);
        check("R6 mem_access_ok open", {7'b0, mem_access_ok}, 8'h01);
        check("R8 suspend on", {7'b0, suspend_en}, 8'h01);
        check("R9 disable bit", {7'b0, hfb_en}, 8'h00);
        access(0, 8'h1B, 8'h00, 8'h41, 1'b0, "R7 misc layout");
        // R1/R2: frozen straps
        access(0, 8'h1C, 8'h00, 8'h5A, 1'b0, "R2 strap low");
        access(0, 8'h1D, 8'h00, 8'hA5, 1'b0, "R1 strap high");
        access(1, 8'h1C, 8'h00, 8'h00, 1'b0, "R2 write strap open");
        access(0, 8'h1C, 8'h00, 8'h5A, 1'b0, "R2 strap after write");
        strap_in = 16'h0000;
        access(0, 8'h1D, 8'h00, 8'hA5, 1'b0, "R1 strap pins moved");
        // R11: unmapped read unlocked
        access(0, 8'h40, 8'h00, 8'h00, 1'b0, "R11 unmapped open");
        // R9: single panel
        access(1, 8'h1B, 8'h00, 8'h00, 1'b0, "R8 clear bits");
        check("R8 suspend off", {7'b0, suspend_en}, 8'h00);
        check("R9 enabled", {7'b0, hfb_en}, 8'h01);
        single_panel = 1'b1;
        #1;
        check("R9 single panel", {7'b0, hfb_en}, 8'h00);
        single_panel = 1'b0;
        // R4: relock
        access(1, 8'h1B, 8'h80, 8'h00, 1'b0, "R4 relock write");
        check("R4 relocked", {7'b0, host_locked}, 8'h01);
        access(0, 8'h1D, 8'h00, 8'h00, 1'b1, "R12 relocked read");
        // R1: second reset recaptures
        do_reset(16'h1234);
        @(negedge clk);
        check("R3 locked again", {7'b0, host_locked}, 8'h01);
        access(1, 8'h1B, 8'h00, 8'h00, 1'b0, "R4 unlock again");
        access(0, 8'h1C, 8'h00, 8'h34, 1'b0, "R1 recapture low");
        access(0, 8'h1D, 8'h00, 8'h12, 1'b0, "R1 recapture high");
        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule